// File: doc/BRIEF.md
# Vector Branch Condition Reducer

This block turns a vector of per-element condition bits into one branch decision. Each element below the active vector length is tested against a chosen sense. A predicate mask decides which elements take part. Elements that are masked out are either skipped or replaced by a fixed fill value. The surviving results are then combined by AND (every element must pass) or by OR (any element may pass).

An optional counter-test mode lowers a loop counter by one for every active element whose test fails. With the zero-exit option, the branch is also taken when that counter reaches zero. An unconditional option forces the branch, but the counter still changes.

A caller presents one evaluation with a single-cycle `start` strobe. One clock later the block returns the registered decision, the new counter value and the next fetch address. The next fetch address is the branch target or the fall-through address of the 8-byte prefixed instruction. Both are computed from the address of the instruction's prefix word.

Top module: `vbr_reducer`

## Requirements
- R1: `done` is high for exactly the one cycle after a cycle with `start` high. In any cycle without a preceding `start`, `done` is low and `br_taken`, `ctr_out` and `next_pc` keep their values.
- R2: An active element i passes its test when `elem_cond[i]` equals `opt_sense`, and fails otherwise.
- R3: The predicate mask is chosen by `pred_src` as follows. Code 0 makes every element active. Code 1 uses `int_mask`, code 2 uses `~int_mask`, code 3 uses `cr_mask` and code 4 uses `~cr_mask`. Codes 5 to 7 behave as code 0. Bit i of the mask governs element i.
- R4: An element below the vector length whose mask bit is 0 is treated as follows. With `zero_en` low it is left out of the reduction. With `zero_en` high it contributes the value of `fill_one`.
- R5: With `all_mode` high the condition is the AND of all contributions; with it low, the OR. Elements at index `vec_len` or above never contribute. With no contributions, the condition is 1 for AND and 0 for OR.
- R6: With `opt_uncond` high, `br_taken` is 1, and the counter is updated exactly as it would be otherwise.
- R7: With `ctr_mode` high, `ctr_out` equals `ctr_in` minus the number of active failing elements, clamped at zero. With `ctr_mode` low, `ctr_out` equals `ctr_in`.
- R8: With `ctr_mode` and `opt_zero_exit` both high, the branch is taken when at least one active element failed and the new counter value is zero. This holds even if the reduced condition is false.
- R9: When the branch is taken, `next_pc` is `instr_addr` plus `br_offset` sign-extended to 64 bits. When it is not taken, `next_pc` is `instr_addr` + 8. `instr_addr` is the address of the prefix word.
- R10: While `rst_n` is low, `done`, `br_taken`, `ctr_out` and `next_pc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Evaluate the presented inputs this cycle |
| vec_len | input | VLW | Number of elements taking part (0 to MAX_VL) |
| elem_cond | input | MAX_VL | Per-element condition bits |
| int_mask | input | MAX_VL | Integer-register predicate bits |
| cr_mask | input | MAX_VL | Condition-register predicate bits |
| pred_src | input | 3 | Predicate source code (R3) |
| opt_uncond | input | 1 | Force the branch taken |
| opt_sense | input | 1 | Bit value an element must show to pass |
| opt_zero_exit | input | 1 | Allow a counter reaching zero to take the branch |
| zero_en | input | 1 | Substitute masked-out elements instead of skipping them |
| fill_one | input | 1 | Substitute value for masked-out elements |
| all_mode | input | 1 | 1: AND reduction, 0: OR reduction |
| ctr_mode | input | 1 | Counter-test mode enable |
| ctr_in | input | XLEN | Counter value before this evaluation |
| instr_addr | input | XLEN | Address of the prefix word of the branch |
| br_offset | input | OFS_W | Signed byte offset of the target |
| done | output | 1 | Result valid pulse |
| br_taken | output | 1 | Branch decision |
| ctr_out | output | XLEN | Counter value after this evaluation |
| next_pc | output | XLEN | Next fetch address |

## Verification
The decision logic has no state beyond its output register, so any internal fault shows up at the ports on the `done` cycle of the evaluation that exercises it. A wrong element inversion or predicate source flips `br_taken` only for particular combinations of mask and condition bits. For that reason the bench sweeps every combination of condition, mask and vector length on a 4-element configuration. A wrong failure count shows up as an off-by-some `ctr_out` and, at the zero boundary, as a spurious or missing zero exit. An offset or fall-through error shows up in `next_pc` on the same cycle.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

   typedef enum logic [2:0] {
      PSRC_NONE  = 3'd0,
      PSRC_INT   = 3'd1,
      PSRC_INT_N = 3'd2,
      PSRC_CR    = 3'd3,
      PSRC_CR_N  = 3'd4
   } pred_src_e;

   // Prefixed instruction: 4-byte prefix word plus 4-byte suffix word
   localparam int unsigned INSN_BYTES = 8;

endpackage

// File: rtl/vbr_pred_sel.sv
module vbr_pred_sel
   import vbr_pkg::*;
#(
   parameter int unsigned MAX_VL = 64
) (
   input  logic [MAX_VL-1:0] int_mask,
   input  logic [MAX_VL-1:0] cr_mask,
   input  logic [2:0]        pred_src,
   output logic [MAX_VL-1:0] pmask
);

   pred_src_e src;

   always_comb begin
      src = pred_src_e'(pred_src);
      case (src)
         PSRC_INT:   pmask = int_mask;
         PSRC_INT_N: pmask = ~int_mask;
         PSRC_CR:    pmask = cr_mask;
         PSRC_CR_N:  pmask = ~cr_mask;
         default:    pmask = '1;
      endcase
   end

endmodule

// File: rtl/vbr_elem_reduce.sv
module vbr_elem_reduce #(
   parameter int unsigned MAX_VL = 64,
   localparam int unsigned VLW  = $clog2(MAX_VL + 1)
) (
   input  logic [MAX_VL-1:0] elem_cond,
   input  logic [MAX_VL-1:0] pmask,
   input  logic [VLW-1:0]    vec_len,
   input  logic              opt_sense,
   input  logic              zero_en,
   input  logic              fill_one,
   input  logic              all_mode,
   output logic              red_ok,
   output logic [MAX_VL-1:0] fail_vec
);

   logic [MAX_VL-1:0] and_term;
   logic [MAX_VL-1:0] or_term;

   for (genvar i = 0; i < MAX_VL; i++) begin : g_elem
      localparam logic [VLW-1:0] IDX = VLW'(i);
      logic in_range, active, pass, contrib_en, contrib_val;

      always_comb begin
         in_range    = IDX < vec_len;
         active      = in_range & pmask[i];
         pass        = ~(elem_cond[i] ^ opt_sense);
         contrib_en  = active | (in_range & ~pmask[i] & zero_en);
         contrib_val = active ? pass : fill_one;
      end

      // Absent contributions are identity for the selected operator
      assign and_term[i] = ~contrib_en | contrib_val;
      assign or_term[i]  =  contrib_en & contrib_val;
      assign fail_vec[i] =  active & ~pass;
   end

   assign red_ok = all_mode ? (&and_term) : (|or_term);

endmodule

// File: rtl/vbr_ctr_update.sv
module vbr_ctr_update #(
   parameter int unsigned MAX_VL = 64,
   parameter int unsigned XLEN   = 64,
   localparam int unsigned VLW   = $clog2(MAX_VL + 1)
) (
   input  logic [MAX_VL-1:0] fail_vec,
   input  logic [XLEN-1:0]   ctr_in,
   input  logic              ctr_mode,
   input  logic              opt_zero_exit,
   output logic [XLEN-1:0]   ctr_next,
   output logic              ctr_exit
);

   function automatic logic [VLW-1:0] count_ones(input logic [MAX_VL-1:0] v);
      logic [VLW-1:0] acc;
      acc = '0;
      for (int k = 0; k < MAX_VL; k++) begin
         acc = acc + {{(VLW-1){1'b0}}, v[k]};
      end
      return acc;
   endfunction

   logic [VLW-1:0]  n_fail;
   logic [XLEN-1:0] n_fail_x;

   always_comb begin
      n_fail   = count_ones(fail_vec);
      n_fail_x = {{(XLEN-VLW){1'b0}}, n_fail};
      if (!ctr_mode)
         ctr_next = ctr_in;
      else if (ctr_in < n_fail_x)
         ctr_next = '0;
      else
         ctr_next = ctr_in - n_fail_x;
      ctr_exit = ctr_mode & opt_zero_exit & (n_fail != '0) & (ctr_next == '0);
   end

endmodule

// File: rtl/vbr_reducer.sv
module vbr_reducer
   import vbr_pkg::*;
#(
   parameter int unsigned MAX_VL = 64,
   parameter int unsigned XLEN   = 64,
   parameter int unsigned OFS_W  = 24,
   localparam int unsigned VLW   = $clog2(MAX_VL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VLW-1:0]    vec_len,
   input  logic [MAX_VL-1:0] elem_cond,
   input  logic [MAX_VL-1:0] int_mask,
   input  logic [MAX_VL-1:0] cr_mask,
   input  logic [2:0]        pred_src,
   input  logic              opt_uncond,
   input  logic              opt_sense,
   input  logic              opt_zero_exit,
   input  logic              zero_en,
   input  logic              fill_one,
   input  logic              all_mode,
   input  logic              ctr_mode,
   input  logic [XLEN-1:0]   ctr_in,
   input  logic [XLEN-1:0]   instr_addr,
   input  logic [OFS_W-1:0]  br_offset,
   output logic              done,
   output logic              br_taken,
   output logic [XLEN-1:0]   ctr_out,
   output logic [XLEN-1:0]   next_pc
);

   if (MAX_VL < 2 || MAX_VL > 64) begin : g_bad_vl
      $error("vbr_reducer: MAX_VL must lie in 2..64");
   end
   if (OFS_W < 2 || OFS_W >= XLEN) begin : g_bad_ofs
      $error("vbr_reducer: OFS_W must lie in 2..XLEN-1");
   end
   if (XLEN <= VLW) begin : g_bad_xlen
      $error("vbr_reducer: XLEN too narrow for the failure count");
   end

   localparam logic [XLEN-1:0] FALL_STEP = XLEN'(INSN_BYTES);

   logic [MAX_VL-1:0] pmask;
   logic [MAX_VL-1:0] fail_vec;
   logic              red_ok;
   logic [XLEN-1:0]   ctr_next;
   logic              ctr_exit;
   logic              take_c;
   logic [XLEN-1:0]   ofs_x;
   logic [XLEN-1:0]   pc_c;

   vbr_pred_sel #(.MAX_VL(MAX_VL)) u_pred (
      .int_mask (int_mask),
      .cr_mask  (cr_mask),
      .pred_src (pred_src),
      .pmask    (pmask)
   );

   vbr_elem_reduce #(.MAX_VL(MAX_VL)) u_red (
      .elem_cond (elem_cond),
      .pmask     (pmask),
      .vec_len   (vec_len),
      .opt_sense (opt_sense),
      .zero_en   (zero_en),
      .fill_one  (fill_one),
      .all_mode  (all_mode),
      .red_ok    (red_ok),
      .fail_vec  (fail_vec)
   );

   vbr_ctr_update #(.MAX_VL(MAX_VL), .XLEN(XLEN)) u_ctr (
      .fail_vec      (fail_vec),
      .ctr_in        (ctr_in),
      .ctr_mode      (ctr_mode),
      .opt_zero_exit (opt_zero_exit),
      .ctr_next      (ctr_next),
      .ctr_exit      (ctr_exit)
   );

   always_comb begin
      take_c = opt_uncond | red_ok | ctr_exit;
      ofs_x  = {{(XLEN-OFS_W){br_offset[OFS_W-1]}}, br_offset};
      pc_c   = take_c ? (instr_addr + ofs_x) : (instr_addr + FALL_STEP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         br_taken <= 1'b0;
         ctr_out  <= '0;
         next_pc  <= '0;
      end else begin
         done <= start;
         if (start) begin
            br_taken <= take_c;
            ctr_out  <= ctr_next;
            next_pc  <= pc_c;
         end
      end
   end

   // R1: result pulse timing and output hold
   p_done_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(br_taken) && $stable(ctr_out) && $stable(next_pc)));
   // R6: forced branch
   p_uncond_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && opt_uncond) |=> br_taken);
   // R7: counter never grows, and is untouched outside counter-test mode
   p_ctr_nogrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (ctr_out <= $past(ctr_in)));
   p_ctr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !ctr_mode) |=> (ctr_out == $past(ctr_in)));
   // R9: fall-through skips the whole prefixed instruction
   p_fallthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (br_taken || (next_pc == $past(instr_addr) + FALL_STEP)));

endmodule

// File: tb/vbr_reducer_tb.sv
module vbr_reducer_tb_top;

   localparam int unsigned MAX_VL   = 4;
   localparam int unsigned XLEN     = 64;
   localparam int unsigned OFS_W    = 16;
   localparam int unsigned VLW      = $clog2(MAX_VL + 1);
   localparam time         CLK_PER  = 10ns;
   localparam int          WD_LIMIT = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [VLW-1:0]    vec_len = '0;
   logic [MAX_VL-1:0] elem_cond = '0, int_mask = '0, cr_mask = '0;
   logic [2:0]        pred_src = '0;
   logic              opt_uncond = 0, opt_sense = 0, opt_zero_exit = 0;
   logic              zero_en = 0, fill_one = 0, all_mode = 0, ctr_mode = 0;
   logic [XLEN-1:0]   ctr_in = '0, instr_addr = '0;
   logic [OFS_W-1:0]  br_offset = '0;
   logic              done, br_taken;
   logic [XLEN-1:0]   ctr_out, next_pc;

   int n_tests = 0;
   int n_fail  = 0;
   int n_vec   = 0;

   always #(CLK_PER/2) clk = ~clk;

   vbr_reducer #(.MAX_VL(MAX_VL), .XLEN(XLEN), .OFS_W(OFS_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
      .elem_cond(elem_cond), .int_mask(int_mask), .cr_mask(cr_mask),
      .pred_src(pred_src), .opt_uncond(opt_uncond), .opt_sense(opt_sense),
      .opt_zero_exit(opt_zero_exit), .zero_en(zero_en), .fill_one(fill_one),
      .all_mode(all_mode), .ctr_mode(ctr_mode), .ctr_in(ctr_in),
      .instr_addr(instr_addr), .br_offset(br_offset), .done(done),
      .br_taken(br_taken), .ctr_out(ctr_out), .next_pc(next_pc)
   );

   task automatic check(input bit ok, input string req, input logic [XLEN-1:0] act,
                        input logic [XLEN-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         if (n_fail < 20)
            $display("FAIL %s: actual 0x%0h expected 0x%0h (vector %0d)", req, act, exp, n_vec);
      end
   endtask

   function automatic logic [MAX_VL-1:0] eff_mask(input int src, input logic [MAX_VL-1:0] im,
                                                  input logic [MAX_VL-1:0] cm);
      case (src)
         1: return im;
         2: return ~im;
         3: return cm;
         4: return ~cm;
         default: return '1;
      endcase
   endfunction

   // Expected result, built from R2, R4, R5, R6, R7, R8
   task automatic model(output bit tk, output logic [XLEN-1:0] co);
      logic [MAX_VL-1:0] pm;
      int  fails;
      bit  red;
      bit  p;
      pm    = eff_mask(int'(pred_src), int_mask, cr_mask);
      fails = 0;
      red   = all_mode;
      for (int i = 0; i < int'(vec_len); i++) begin
         if (pm[i]) begin
            p = (elem_cond[i] == opt_sense);
            if (!p) fails++;
            red = all_mode ? (red & p) : (red | p);
         end else if (zero_en) begin
            red = all_mode ? (red & fill_one) : (red | fill_one);
         end
      end
      if (!ctr_mode) co = ctr_in;
      else if (ctr_in < XLEN'(fails)) co = '0;
      else co = ctr_in - XLEN'(fails);
      tk = opt_uncond | red | (ctr_mode & opt_zero_exit & (fails != 0) & (co == '0));
   endtask

   // Drive the prepared inputs with a start pulse, then check on the following negedge
   task automatic run_vec(input string tag);
      bit              tk;
      logic [XLEN-1:0] co, pc;
      n_vec++;
      instr_addr = 64'h0000_0000_0040_0000 + XLEN'(n_vec * 4);
      br_offset  = OFS_W'(n_vec * 2371);
      model(tk, co);
      pc = tk ? instr_addr + {{(XLEN-OFS_W){br_offset[OFS_W-1]}}, br_offset}
              : instr_addr + 64'd8;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b1, "R1", XLEN'(done), 1);
      check(br_taken == tk, tag, XLEN'(br_taken), XLEN'(tk));
      check(ctr_out == co, "R7", ctr_out, co);
      check(next_pc == pc, "R9", next_pc, pc);
   endtask

   initial begin : watchdog
      repeat (WD_LIMIT) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [XLEN-1:0] hold_ctr, hold_pc;
      bit              hold_tk;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(done == 0 && br_taken == 0, "R10", XLEN'({done, br_taken}), 0);
      check(ctr_out == '0, "R10", ctr_out, 0);
      check(next_pc == '0, "R10", next_pc, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Sweep A: integer mask, every condition/mask/length/flag combination (R2 R4 R5)
      pred_src = 3'd1;
      for (int c = 0; c < 16; c++)
         for (int m = 0; m < 16; m++)
            for (int l = 0; l <= int'(MAX_VL); l++)
               for (int f = 0; f < 16; f++) begin
                  elem_cond = MAX_VL'(c); int_mask = MAX_VL'(m); vec_len = VLW'(l);
                  all_mode = f[0]; opt_sense = f[1]; zero_en = f[2]; fill_one = f[3];
                  run_vec("R2 R4 R5");
               end

      // Sweep B: every predicate source (R3)
      vec_len = VLW'(MAX_VL); opt_sense = 1; zero_en = 1; fill_one = 0;
      for (int s = 0; s < 5; s++)
         for (int c = 0; c < 16; c++)
            for (int m = 0; m < 16; m++)
               for (int k = 0; k < 2; k++) begin
                  pred_src = 3'(s); elem_cond = MAX_VL'(c); int_mask = MAX_VL'(m);
                  cr_mask = MAX_VL'(m ^ 4'h6); all_mode = k[0];
                  run_vec("R3");
               end
      // R3: reserved source codes act as no predication
      pred_src = 3'd6; all_mode = 1; elem_cond = 4'hF; int_mask = 4'h0; cr_mask = 4'h0;
      run_vec("R3");

      // Sweep C: counter-test mode, zero exit and forced branch (R6 R7 R8)
      pred_src = 3'd1; zero_en = 0; all_mode = 1; opt_sense = 1; ctr_mode = 1;
      for (int c = 0; c < 16; c++)
         for (int m = 0; m < 16; m++)
            for (int v = 0; v < 4; v++)
               for (int o = 0; o < 4; o++) begin
                  elem_cond = MAX_VL'(c); int_mask = MAX_VL'(m); ctr_in = XLEN'(v);
                  opt_zero_exit = o[0]; opt_uncond = o[1];
                  run_vec("R6 R8");
               end

      // R8: exit on zero although every condition fails in OR mode
      all_mode = 0; elem_cond = 4'h0; int_mask = 4'hF; ctr_in = 64'd4;
      opt_zero_exit = 1; opt_uncond = 0;
      run_vec("R8");
      check(br_taken == 1 && ctr_out == 0, "R8", XLEN'(br_taken), 1);
      // R7: large counter, no clamp
      ctr_in = 64'h1_0000_0000; elem_cond = 4'h5;
      run_vec("R7");
      check(ctr_out == 64'h0_FFFF_FFFE, "R7", ctr_out, 64'h0_FFFF_FFFE);

      // R9: negative offset on a forced branch
      ctr_mode = 0; opt_uncond = 1;
      start = 1'b1; instr_addr = 64'h2000_0000_0000_1000; br_offset = 16'hFFF0;
      @(negedge clk);
      start = 1'b0;
      check(next_pc == 64'h2000_0000_0000_0FF0, "R9", next_pc, 64'h2000_0000_0000_0FF0);

      // R1: no start, no pulse, outputs held
      hold_tk = br_taken; hold_ctr = ctr_out; hold_pc = next_pc;
      ctr_in = 64'h55; instr_addr = 64'h9999; elem_cond = 4'h0;
      repeat (3) @(negedge clk);
      check(done == 0, "R1", XLEN'(done), 0);
      check(br_taken == hold_tk && ctr_out == hold_ctr, "R1", ctr_out, hold_ctr);
      check(next_pc == hold_pc, "R1", next_pc, hold_pc);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule